// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a processor core and decides which of its level-sensitive interrupt request lines, if any, the core should service next. Every line carries its own enable bit and its own priority bit. A set priority bit places the line at level 2, the high level. A clear bit leaves it at level 1. Among eligible lines the controller picks a winner. It records the winner's vector number in a cause register and raises a one-cycle take pulse that carries the vector and the level.

The controller keeps a small status word with a global enable and an active flag for each level. On entry to a handler, the status in force is copied into that level's save register and the level's active flag is set. A level-2 request can therefore pre-empt a running level-1 handler. Each level has a return strobe, and pulsing it copies the saved word back into the status word.

Software reaches the enables, priority bits, status, save registers, cause and a read-only configuration word through a simple register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `intc_top`

## Requirements
- R1: Register address 0 holds one enable bit per line (bit n for line n). It resets to zero. While a line's enable bit is zero, that line is never taken, and writing zero disables every line.
- R2: Register address 1 holds one priority bit per line. A set bit makes the line a level-2 request and a clear bit makes it level 1. It resets to zero.
- R3: Requests are level-sensitive and are never latched. A line is taken only if it is high at the clock edge where the decision is made. A request that falls again before it can be taken leaves no trace.
- R4: Among pending, enabled lines of one level, the lowest-numbered line wins. When an eligible level-2 line and an eligible level-1 line exist in the same cycle, the level-2 line wins.
- R5: The status word at address 2 has the level-1 enable in bit 0, the level-2 enable in bit 1, the level-1 active flag in bit 2 and the level-2 active flag in bit 3. It resets to zero. A level-1 line is taken only when bit 0 is set and bits 2 and 3 are clear.
- R6: A level-2 line is taken only when bit 1 of the status word is set and bit 3 is clear. This allows level 2 to pre-empt an active level-1 handler.
- R7: The take output pulses for one cycle, starting on the cycle after the deciding clock edge. It is low after reset. On a level-1 take, the prior status is copied to the level-1 save register (address 3) and bit 2 is set. A pulse on the level-1 return strobe copies that register back into the status word.
- R8: On a level-2 take, the prior status is copied to the level-2 save register (address 4) and bit 3 is set. The level-2 return strobe restores the status from that register. When both return strobes pulse together, the level-2 restore wins.
- R9: The cause register (address 5, read-only) resets to zero and holds the vector number of the most recently taken line. The take vector output shows the same value.
- R10: The configuration word (address 6, read-only) encodes the line count in bits 1:0: 2 means 8 lines, 0 means 16 lines, 1 means 32 lines.
- R11: Lines 0 to 2 are reserved and never raise an interrupt. Their enable and priority bits ignore writes and read back as zero.
- R12: In a cycle with a register write or a return strobe, no interrupt is taken. A request still pending is taken on a later cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | NUM_LINES | Level-sensitive request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational |
| ret_l1 | input | 1 | Level-1 handler return strobe |
| ret_l2 | input | 1 | Level-2 handler return strobe |
| take_irq | output | 1 | One-cycle pulse when an interrupt is taken |
| take_vec | output | $clog2(NUM_LINES) | Vector number of the taken line |
| take_lvl2 | output | 1 | High when the taken line is level 2 |

## Verification
The bench nests a level-2 handler inside a level-1 handler. It checks the saved words and the restored status at each return. A design that saved the status after setting the active flag, or that restored from the wrong save register, would leave a stale active bit and lock out later interrupts.

The bench holds lower-priority lines pending while a handler runs and checks that they are taken only once the gating flags allow it, with the lowest-numbered line taken first. An arbiter scanning from the top, or a missing A2 check on level 1, would show up as an out-of-order take in the scoreboard.

Reserved lines, disabled lines, a pulse that falls before it can be taken, and both return strobes in one cycle are also driven. A design that latched requests, or let line 0 through, would produce a take that no expectation covers.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // Status word layout, MSB first: a2 a1 e2 e1
   typedef struct packed {
      logic a2;
      logic a1;
      logic e2;
      logic e1;
   } intc_sts_t;

   localparam int REG_AW = 3;

   localparam logic [REG_AW-1:0] ADDR_ENA   = 3'd0;
   localparam logic [REG_AW-1:0] ADDR_LVL   = 3'd1;
   localparam logic [REG_AW-1:0] ADDR_STS   = 3'd2;
   localparam logic [REG_AW-1:0] ADDR_SAV1  = 3'd3;
   localparam logic [REG_AW-1:0] ADDR_SAV2  = 3'd4;
   localparam logic [REG_AW-1:0] ADDR_CAUSE = 3'd5;
   localparam logic [REG_AW-1:0] ADDR_CFG   = 3'd6;

endpackage

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int NUM_LINES  = 32,
   parameter int RSVD_LINES = 3,
   parameter int DW         = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_AW-1:0]    addr,
   input  logic [DW-1:0]        wdata,
   output logic [NUM_LINES-1:0] ena_q,
   output logic [NUM_LINES-1:0] lvl_q
);

   logic wr_ena;
   logic wr_lvl;

   assign wr_ena = wr_en && (addr == ADDR_ENA);
   assign wr_lvl = wr_en && (addr == ADDR_LVL);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      if (i < RSVD_LINES) begin : g_rsvd
         logic unused_wbit;
         assign unused_wbit = wdata[i];
         assign ena_q[i]    = 1'b0;
         assign lvl_q[i]    = 1'b0;
      end else begin : g_live
         logic ena_r;
         logic lvl_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ena_r <= 1'b0;
               lvl_r <= 1'b0;
            end else begin
               if (wr_ena) ena_r <= wdata[i];
               if (wr_lvl) lvl_r <= wdata[i];
            end
         end
         assign ena_q[i] = ena_r;
         assign lvl_q[i] = lvl_r;
      end
   end

   if (DW > NUM_LINES) begin : g_wide
      logic unused_upper;
      assign unused_upper = ^wdata[DW-1:NUM_LINES];
   end

endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
   parameter int NUM_LINES = 32,
   localparam int VEC_W    = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] pend,
   output logic                 hit,
   output logic [VEC_W-1:0]     idx
);

   // Scan from the top so that the last assignment is the lowest set bit
   always_comb begin
      hit = |pend;
      idx = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (pend[i]) idx = VEC_W'(i);
      end
   end

endmodule

// File: rtl/intc_seq.sv
module intc_seq
   import intc_pkg::*;
#(
   parameter int NUM_LINES = 32,
   localparam int VEC_W    = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sts,
   input  logic             wr_sav1,
   input  logic             wr_sav2,
   input  logic [3:0]       wdata,
   input  logic             p1_hit,
   input  logic [VEC_W-1:0] p1_idx,
   input  logic             p2_hit,
   input  logic [VEC_W-1:0] p2_idx,
   input  logic             ret_l1,
   input  logic             ret_l2,
   output intc_sts_t        sts_q,
   output intc_sts_t        sav1_q,
   output intc_sts_t        sav2_q,
   output logic [VEC_W-1:0] cause_q,
   output logic             take_q,
   output logic             take_l2_q
);

   logic quiet;
   logic go1;
   logic go2;

   assign quiet = wr_en | ret_l1 | ret_l2;
   assign go2   = !quiet && sts_q.e2 && !sts_q.a2 && p2_hit;
   assign go1   = !quiet && !go2 && sts_q.e1 && !sts_q.a1 && !sts_q.a2 && p1_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q     <= '0;
         sav1_q    <= '0;
         sav2_q    <= '0;
         cause_q   <= '0;
         take_q    <= 1'b0;
         take_l2_q <= 1'b0;
      end else begin
         take_q    <= go1 | go2;
         take_l2_q <= go2;

         if (wr_sts)      sts_q    <= intc_sts_t'(wdata);
         else if (ret_l2) sts_q    <= sav2_q;
         else if (ret_l1) sts_q    <= sav1_q;
         else if (go2)    sts_q.a2 <= 1'b1;
         else if (go1)    sts_q.a1 <= 1'b1;

         if (wr_sav1)  sav1_q <= intc_sts_t'(wdata);
         else if (go1) sav1_q <= sts_q;

         if (wr_sav2)  sav2_q <= intc_sts_t'(wdata);
         else if (go2) sav2_q <= sts_q;

         if (go2)      cause_q <= p2_idx;
         else if (go1) cause_q <= p1_idx;
      end
   end

endmodule

// File: rtl/intc_top.sv
module intc_top
   import intc_pkg::*;
#(
   parameter int NUM_LINES  = 32,
   parameter int RSVD_LINES = 3,
   parameter int DW         = 32,
   localparam int VEC_W     = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_req,
   input  logic                 reg_wr,
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic [DW-1:0]        reg_wdata,
   output logic [DW-1:0]        reg_rdata,
   input  logic                 ret_l1,
   input  logic                 ret_l2,
   output logic                 take_irq,
   output logic [VEC_W-1:0]     take_vec,
   output logic                 take_lvl2
);

   if (!(NUM_LINES == 8 || NUM_LINES == 16 || NUM_LINES == 32)) begin : g_bad_lines
      $error("intc_top: NUM_LINES must be 8, 16 or 32");
   end
   if (RSVD_LINES >= NUM_LINES) begin : g_bad_rsvd
      $error("intc_top: RSVD_LINES must be below NUM_LINES");
   end
   if (DW < NUM_LINES) begin : g_bad_dw
      $error("intc_top: DW must cover NUM_LINES");
   end

   logic [NUM_LINES-1:0] ena_q;
   logic [NUM_LINES-1:0] lvl_q;
   logic [NUM_LINES-1:0] pend;
   logic                 p1_hit;
   logic                 p2_hit;
   logic [VEC_W-1:0]     p1_idx;
   logic [VEC_W-1:0]     p2_idx;
   intc_sts_t            sts_q;
   intc_sts_t            sav1_q;
   intc_sts_t            sav2_q;
   logic [VEC_W-1:0]     cause_q;
   logic [1:0]           cfg_code;

   if (NUM_LINES == 8) begin : g_cfg8
      assign cfg_code = 2'd2;
   end else if (NUM_LINES == 16) begin : g_cfg16
      assign cfg_code = 2'd0;
   end else begin : g_cfg32
      assign cfg_code = 2'd1;
   end

   intc_regs #(
      .NUM_LINES (NUM_LINES),
      .RSVD_LINES(RSVD_LINES),
      .DW        (DW)
   ) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(reg_wr),
      .addr (reg_addr),
      .wdata(reg_wdata),
      .ena_q(ena_q),
      .lvl_q(lvl_q)
   );

   assign pend = irq_req & ena_q;

   intc_arb #(.NUM_LINES(NUM_LINES)) u_arb_l1 (
      .pend(pend & ~lvl_q),
      .hit (p1_hit),
      .idx (p1_idx)
   );

   intc_arb #(.NUM_LINES(NUM_LINES)) u_arb_l2 (
      .pend(pend & lvl_q),
      .hit (p2_hit),
      .idx (p2_idx)
   );

   intc_seq #(.NUM_LINES(NUM_LINES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .wr_sts   (reg_wr && reg_addr == ADDR_STS),
      .wr_sav1  (reg_wr && reg_addr == ADDR_SAV1),
      .wr_sav2  (reg_wr && reg_addr == ADDR_SAV2),
      .wdata    (reg_wdata[3:0]),
      .p1_hit   (p1_hit),
      .p1_idx   (p1_idx),
      .p2_hit   (p2_hit),
      .p2_idx   (p2_idx),
      .ret_l1   (ret_l1),
      .ret_l2   (ret_l2),
      .sts_q    (sts_q),
      .sav1_q   (sav1_q),
      .sav2_q   (sav2_q),
      .cause_q  (cause_q),
      .take_q   (take_irq),
      .take_l2_q(take_lvl2)
   );

   assign take_vec = cause_q;

   always_comb begin
      case (reg_addr)
         ADDR_ENA:   reg_rdata = DW'(ena_q);
         ADDR_LVL:   reg_rdata = DW'(lvl_q);
         ADDR_STS:   reg_rdata = DW'(sts_q);
         ADDR_SAV1:  reg_rdata = DW'(sav1_q);
         ADDR_SAV2:  reg_rdata = DW'(sav2_q);
         ADDR_CAUSE: reg_rdata = DW'(cause_q);
         ADDR_CFG:   reg_rdata = DW'(cfg_code);
         default:    reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/intc_chk.sv
module intc_chk
   import intc_pkg::*;
#(
   parameter int NUM_LINES  = 32,
   parameter int RSVD_LINES = 3,
   localparam int VEC_W     = $clog2(NUM_LINES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_req,
   input logic                 reg_wr,
   input logic                 ret_l1,
   input logic                 ret_l2,
   input logic                 take_irq,
   input logic [VEC_W-1:0]     take_vec,
   input logic                 take_lvl2,
   input intc_sts_t            sts,
   input intc_sts_t            sav1,
   input intc_sts_t            sav2
);

   logic [NUM_LINES-1:0] req_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_d <= '0;
      else        req_d <= irq_req;
   end

   AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> (int'(take_vec) >= RSVD_LINES));                          // R11

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> req_d[take_vec]);                                         // R3

   AST_L1_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq && !take_lvl2) |-> ($past(sts.e1) && !$past(sts.a1) && !$past(sts.a2))); // R5

   AST_L2_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq && take_lvl2) |-> ($past(sts.e2) && !$past(sts.a2)));       // R6

   AST_L1_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq && !take_lvl2) |-> (sts.a1 && sav1 == $past(sts)));         // R7

   AST_L2_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq && take_lvl2) |-> (sts.a2 && sav2 == $past(sts)));          // R8

   AST_RET2_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_l2 && !reg_wr) |=> (sts == $past(sav2)));                        // R8

   AST_QUIET_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr || ret_l1 || ret_l2) |=> !take_irq);                          // R12

endmodule

bind intc_top intc_chk #(
   .NUM_LINES (NUM_LINES),
   .RSVD_LINES(RSVD_LINES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_req  (irq_req),
   .reg_wr   (reg_wr),
   .ret_l1   (ret_l1),
   .ret_l2   (ret_l2),
   .take_irq (take_irq),
   .take_vec (take_vec),
   .take_lvl2(take_lvl2),
   .sts      (sts_q),
   .sav1     (sav1_q),
   .sav2     (sav2_q)
);

// File: tb/intc_top_tb.sv
`timescale 1ns/1ps
module intc_top_tb;

   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq = '0;
   logic          wr = 1'b0;
   logic [2:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          rl1 = 1'b0;
   logic          rl2 = 1'b0;
   logic          take;
   logic [4:0]    vec;
   logic          lvl2;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct packed {
      logic [4:0] v;
      logic       l2;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   intc_top u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_req  (irq),
      .reg_wr   (wr),
      .reg_addr (addr),
      .reg_wdata(wdata),
      .reg_rdata(rdata),
      .ret_l1   (rl1),
      .ret_l2   (rl2),
      .take_irq (take),
      .take_vec (vec),
      .take_lvl2(lvl2)
   );

   // Scoreboard monitor: every take must match the next expected item (R4, R7, R8, R9)
   always @(negedge clk) begin
      if (rst_n && take) begin
         n_chk++;
         if (q.size() == 0) begin
            n_bad++;
            $display("FAIL R4 take order: actual vec=%0d l2=%0d expected none", vec, lvl2);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (e.v !== vec || e.l2 !== lvl2) begin
               n_bad++;
               $display("FAIL R4 take order: actual vec=%0d l2=%0d expected vec=%0d l2=%0d",
                        vec, lvl2, e.v, e.l2);
            end
         end
      end
   end

   task automatic expect_take(input int v, input bit l2);
      exp_t e;
      e.v  = 5'(v);
      e.l2 = l2;
      q.push_back(e);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
      addr = a;
      #1;
      chk(tag, rdata, exp);
   endtask

   task automatic do_ret(input bit one, input bit two);
      @(negedge clk);
      rl1 = one; rl2 = two;
      @(negedge clk);
      rl1 = 1'b0; rl2 = 1'b0;
   endtask

   initial begin : watchdog
      #(20 * 20000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      idle(3);
      rst_n = 1'b1;
      idle(1);

      chk("R7 take low after reset", 32'(take), 32'd0);
      rd_chk("R1 enable reset", 3'd0, 32'h0);
      rd_chk("R2 level reset", 3'd1, 32'h0);
      rd_chk("R5 status reset", 3'd2, 32'h0);
      rd_chk("R9 cause reset", 3'd5, 32'h0);
      rd_chk("R10 config code", 3'd6, 32'h1);

      wr_reg(3'd0, 32'hFFFF_FFFF);
      rd_chk("R11 enable reserved bits", 3'd0, 32'hFFFF_FFF8);
      wr_reg(3'd1, 32'hFFFF_FFFF);
      rd_chk("R11 level reserved bits", 3'd1, 32'hFFFF_FFF8);
      wr_reg(3'd1, (32'd1 << 20) | (32'd1 << 25));
      rd_chk("R2 level readback", 3'd1, (32'd1 << 20) | (32'd1 << 25));

      // global enables clear: no take
      irq = N'(1) << 5;
      idle(3);
      rd_chk("R5 no take with E1 clear", 3'd2, 32'h0);
      irq = '0;

      wr_reg(3'd2, 32'h3);
      // R1: all enables zero blocks both levels
      wr_reg(3'd0, 32'h0);
      irq = (N'(1) << 9) | (N'(1) << 25);
      idle(3);
      rd_chk("R1 disabled lines not taken", 3'd2, 32'h3);
      irq = '0;
      wr_reg(3'd0, 32'hFFFF_FFFF);

      // R11: reserved lines silent
      irq = N'(7);
      idle(3);
      rd_chk("R11 reserved lines silent", 3'd2, 32'h3);
      irq = '0;

      // level-1 entry, lowest line wins
      expect_take(5, 1'b0);
      irq = (N'(1) << 9) | (N'(1) << 5);
      idle(2);
      rd_chk("R7 status after L1 entry", 3'd2, 32'h7);
      rd_chk("R7 L1 save", 3'd3, 32'h3);
      rd_chk("R9 cause after L1", 3'd5, 32'd5);

      // R3: short pulse on a level-1 line while blocked
      irq[12] = 1'b1;
      idle(2);
      irq[12] = 1'b0;

      // level-2 pre-empts level 1
      expect_take(20, 1'b1);
      irq = irq | (N'(1) << 25) | (N'(1) << 20);
      idle(2);
      rd_chk("R6 status after L2 entry", 3'd2, 32'hF);
      rd_chk("R8 L2 save", 3'd4, 32'h7);
      rd_chk("R9 cause after L2", 3'd5, 32'd20);
      idle(3);

      irq[20] = 1'b0;
      expect_take(25, 1'b1);
      do_ret(1'b0, 1'b1);
      rd_chk("R8 restore on L2 return", 3'd2, 32'h7);
      chk("R12 no take in return cycle", 32'(take), 32'd0);
      idle(2);
      rd_chk("R6 second L2 entry", 3'd2, 32'hF);

      irq[25] = 1'b0;
      do_ret(1'b0, 1'b1);
      rd_chk("R8 restore to L1 active", 3'd2, 32'h7);
      idle(2);

      irq[5] = 1'b0;
      expect_take(9, 1'b0);
      do_ret(1'b1, 1'b0);
      rd_chk("R7 restore on L1 return", 3'd2, 32'h3);
      idle(2);
      rd_chk("R7 next L1 entry", 3'd2, 32'h7);
      rd_chk("R9 cause line 9", 3'd5, 32'd9);
      irq[9] = 1'b0;
      do_ret(1'b1, 1'b0);
      idle(3);
      rd_chk("R3 dropped pulse not latched", 3'd2, 32'h3);

      // both return strobes together: level 2 wins
      expect_take(25, 1'b1);
      irq = N'(1) << 25;
      idle(2);
      irq = '0;
      wr_reg(3'd3, 32'h1);
      do_ret(1'b1, 1'b1);
      rd_chk("R8 L2 restore wins over L1", 3'd2, 32'h3);

      // level 2 beats a lower-numbered level-1 line
      expect_take(25, 1'b1);
      expect_take(4, 1'b0);
      irq = (N'(1) << 4) | (N'(1) << 25);
      idle(3);
      rd_chk("R4 L2 first", 3'd5, 32'd25);
      irq[25] = 1'b0;
      do_ret(1'b0, 1'b1);
      idle(2);
      rd_chk("R4 L1 after L2 return", 3'd5, 32'd4);
      irq = '0;
      do_ret(1'b1, 1'b0);

      // E1 clear, E2 set
      wr_reg(3'd2, 32'h2);
      expect_take(20, 1'b1);
      irq = (N'(1) << 6) | (N'(1) << 20);
      idle(2);
      rd_chk("R6 L2 taken with E1 clear", 3'd2, 32'hA);
      irq[20] = 1'b0;
      do_ret(1'b0, 1'b1);
      idle(3);
      rd_chk("R5 L1 held off by E1", 3'd2, 32'h2);
      irq = '0;

      // E2 clear
      wr_reg(3'd2, 32'h1);
      irq = N'(1) << 25;
      idle(3);
      rd_chk("R6 L2 held off by E2", 3'd2, 32'h1);
      irq = '0;

      idle(2);
      chk("R4 all expected takes seen", 32'(q.size()), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule